// File: doc/BRIEF.md
# I2S to Serial Voltage-DAC Bridge

This block sits between an I2S source and a 16-bit serial-load voltage-output DAC. The DAC shifts a bit in on each rising edge of its shift clock while its active-low select is low, and it transfers the last 16 bits it received to its output when the select rises. The I2S source carries 32-bit two's-complement slots, two per frame (64 BCLK periods per frame). LRCLK low marks the left slot, and each slot's MSB follows the LRCLK change by one BCLK period. The bridge picks one channel, converts it to binary-offset coding and retimes it so that the 16 most significant bits of that slot are the final 16 bits shifted before each latch.

Every register is clocked by BCLK. A rising-edge front stage samples LRCLK and the serial data. Two falling-edge delay chains follow it: one retimes the data and one delays the channel phase to form the select. The DAC shift clock is BCLK ORed with a registered hold level. This keeps the clock parked high for the half of each frame that does not carry the chosen channel. The select rises two bit periods after the hold begins, while the clock is parked and the data line sits at zero. It falls again two bit periods after the clock restarts.

Top module: `i2s_dac_bridge`

## Requirements
- R1: While `rst_n` is low, `dac_cs_n` is 1, `dac_sck` is 1 and `dac_sdi` is 0.
- R2: At each rising edge of `dac_cs_n`, the last 16 bits captured from `dac_sdi` equal `{~w[31], w[30:16]}`. Capture is on rising `dac_sck` while `dac_cs_n` is low, and the first of the 16 is the DAC MSB. Here `w` is the 32-bit slot of the selected channel, sent MSB first and starting one BCLK after the LRCLK change. By default the left slot (LRCLK low) is selected.
- R3: Slot bits 15..0 and all bits of the other channel's slot have no effect on the latched word.
- R4: Between consecutive latches (64 BCLK periods), `dac_sck` makes exactly 32 rising edges and stays high for the rest of the frame. `dac_sdi` is 0 whenever the clock is parked.
- R5: `dac_cs_n` rises exactly once per 64 BCLK periods, on a BCLK falling edge, while `dac_sck` is high and `dac_sdi` is 0.
- R6: `dac_cs_n` falls only after the shift clock has run for two full bit periods, so 30 rising `dac_sck` edges occur while `dac_cs_n` is low in each frame.
- R7: With `CHAN_RIGHT` = 1, the right slot (LRCLK high) is latched under the same rules, 32 BCLK periods later in the frame.
- R8: `dac_sck` rises only together with a rising BCLK edge and falls only together with a falling BCLK edge. `dac_sdi` changes only on falling BCLK edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i2s_bclk | input | 1 | I2S bit clock; clocks every register |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_lrclk | input | 1 | I2S word select, low for the left slot |
| i2s_sdata | input | 1 | I2S serial data, two's complement, MSB first |
| dac_sck | output | 1 | DAC shift clock, parked high outside the active half-frame |
| dac_sdi | output | 1 | DAC serial data, binary offset, MSB first |
| dac_cs_n | output | 1 | DAC select; its rising edge latches the word |

## Verification
The assertions check four things on every BCLK cycle. The select rises only while the clock is parked. The data line is zero whenever the clock is parked. The select opens only after two running clock periods. Successive latches are exactly one 64-bit frame apart. The scenarios cover what a single-cycle property cannot see: the value of the 16-bit word at each latch, the MSB inversion, whether the low slot bits and the neighbouring channel are ignored, the count of shift edges per frame and inside the select window, and both channel choices. Edge-alignment checks on the DAC clock and data pins against BCLK cover the glitch-free gating.

// File: rtl/i2s_dac_bridge_pkg.sv
`timescale 1ns/1ps
package i2s_dac_bridge_pkg;

    // State of the rising-edge front stage
    typedef struct packed {
        logic lr;        // LRCLK as sampled on the last rising edge
        logic quiet;     // 1 while the sampled half-frame is the parked one
        logic msb_next;  // next sample is the MSB of the selected slot
        logic bit_v;     // sampled data bit, MSB already inverted
    } smp_state_t;

    localparam smp_state_t SMP_RESET = '{lr: 1'b1, quiet: 1'b1, msb_next: 1'b0, bit_v: 1'b0};

    // Parked half: the slot that is not selected
    function automatic logic park_level(input logic lr, input logic sel_right);
        return lr ^ sel_right;
    endfunction

endpackage

// File: rtl/i2s_dac_bridge_sampler.sv
`timescale 1ns/1ps
module i2s_dac_bridge_sampler
    import i2s_dac_bridge_pkg::*;
#(
    parameter bit SEL_RIGHT = 1'b0
) (
    input  logic i2s_bclk,
    input  logic rst_n,
    input  logic i2s_lrclk,
    input  logic i2s_sdata,
    output logic smp_bit,
    output logic smp_quiet
);

    smp_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.lr       = i2s_lrclk;
        st_d.quiet    = park_level(i2s_lrclk, SEL_RIGHT);
        // The LRCLK edge into the selected slot is seen one bit before its MSB
        st_d.msb_next = (i2s_lrclk != st_q.lr) && (i2s_lrclk == SEL_RIGHT);
        // Two's complement to binary offset: flip only the slot MSB
        st_d.bit_v    = i2s_sdata ^ st_q.msb_next;
    end

    always_ff @(posedge i2s_bclk or negedge rst_n) begin
        if (!rst_n) st_q <= SMP_RESET;
        else        st_q <= st_d;
    end

    assign smp_bit   = st_q.bit_v;
    assign smp_quiet = st_q.quiet;

    // R2
    msb_pulse_chk: assert property (@(posedge i2s_bclk) disable iff (!rst_n)
        st_q.msb_next |=> !st_q.msb_next);

endmodule

// File: rtl/i2s_dac_bridge_delay.sv
`timescale 1ns/1ps
module i2s_dac_bridge_delay #(
    parameter int DEPTH   = 4,
    parameter bit RST_VAL = 1'b0,
    parameter bit SQUELCH = 1'b0
) (
    input  logic i2s_bclk,
    input  logic rst_n,
    input  logic din,
    input  logic mute,
    output logic dout
);

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        // Force the output stage to zero for the bits that meet a parked clock
        if (SQUELCH && mute) begin
            chain_d[DEPTH-1] = 1'b0;
        end
    end

    // Falling-edge stages: outputs move half a period away from DAC capture
    always_ff @(negedge i2s_bclk or negedge rst_n) begin
        if (!rst_n) chain_q <= {DEPTH{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[DEPTH-1];

endmodule

// File: rtl/i2s_dac_bridge.sv
`timescale 1ns/1ps
module i2s_dac_bridge #(
    parameter int SLOT_W     = 32,
    parameter int WORD_W     = 16,
    parameter int LATCH_DLY  = 2,
    parameter bit CHAN_RIGHT = 1'b0
) (
    input  logic i2s_bclk,
    input  logic rst_n,
    input  logic i2s_lrclk,
    input  logic i2s_sdata,
    output logic dac_sck,
    output logic dac_sdi,
    output logic dac_cs_n
);

    // Data stages so the slot's top WORD_W bits end on the last run edge
    localparam int DATA_DEPTH = SLOT_W - WORD_W;
    localparam int LAT_DEPTH  = LATCH_DLY + 1;
    localparam int FRAME_BCLK = 2 * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BCLK);

    logic smp_bit;
    logic clk_hold;

    i2s_dac_bridge_sampler #(
        .SEL_RIGHT (CHAN_RIGHT)
    ) u_sampler (
        .i2s_bclk  (i2s_bclk),
        .rst_n     (rst_n),
        .i2s_lrclk (i2s_lrclk),
        .i2s_sdata (i2s_sdata),
        .smp_bit   (smp_bit),
        .smp_quiet (clk_hold)
    );

    i2s_dac_bridge_delay #(
        .DEPTH   (DATA_DEPTH),
        .RST_VAL (1'b0),
        .SQUELCH (1'b1)
    ) u_data_dly (
        .i2s_bclk (i2s_bclk),
        .rst_n    (rst_n),
        .din      (smp_bit),
        .mute     (clk_hold),
        .dout     (dac_sdi)
    );

    i2s_dac_bridge_delay #(
        .DEPTH   (LAT_DEPTH),
        .RST_VAL (1'b1),
        .SQUELCH (1'b0)
    ) u_latch_dly (
        .i2s_bclk (i2s_bclk),
        .rst_n    (rst_n),
        .din      (clk_hold),
        .mute     (1'b0),
        .dout     (dac_cs_n)
    );

    // Hold changes on the rising edge, while BCLK is already high
    assign dac_sck = i2s_bclk | clk_hold;

    // ---------------- checks ----------------
    typedef struct packed {
        logic             cs_prev;
        logic             seen;
        logic [CNT_W-1:0] gap;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d         = mon_q;
        mon_d.cs_prev = dac_cs_n;
        if (dac_cs_n && !mon_q.cs_prev) begin
            mon_d.gap  = '0;
            mon_d.seen = 1'b1;
        end else begin
            mon_d.gap  = mon_q.gap + 1'b1;
        end
    end

    always_ff @(posedge i2s_bclk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{cs_prev: 1'b1, seen: 1'b0, gap: '0};
        else        mon_q <= mon_d;
    end

    // R5
    latch_quiet_chk: assert property (@(posedge i2s_bclk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> clk_hold);

    // R4
    sdi_idle_chk: assert property (@(posedge i2s_bclk) disable iff (!rst_n)
        clk_hold |-> !dac_sdi);

    // R6
    cs_open_chk: assert property (@(posedge i2s_bclk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> (!clk_hold && !$past(clk_hold) && !$past(clk_hold, 2)));

    // R5
    frame_period_chk: assert property (@(posedge i2s_bclk) disable iff (!rst_n)
        (dac_cs_n && !mon_q.cs_prev && mon_q.seen) |-> (mon_q.gap == CNT_W'(FRAME_BCLK - 1)));

endmodule

// File: tb/i2s_dac_bridge_test.sv
`timescale 1ns/1ps
module i2s_dac_bridge_test;

    logic bclk  = 1'b0;
    logic rst_n = 1'b0;
    logic lr    = 1'b1;
    logic sd    = 1'b0;

    logic sck_l, sdi_l, cs_l;
    logic sck_r, sdi_r, cs_r;

    int checks = 0;
    int fails  = 0;

    always #10 bclk = ~bclk;  // 50 MHz

    i2s_dac_bridge uut (
        .i2s_bclk (bclk), .rst_n (rst_n), .i2s_lrclk (lr), .i2s_sdata (sd),
        .dac_sck (sck_l), .dac_sdi (sdi_l), .dac_cs_n (cs_l)
    );

    i2s_dac_bridge #(.CHAN_RIGHT(1'b1)) uut_right (
        .i2s_bclk (bclk), .rst_n (rst_n), .i2s_lrclk (lr), .i2s_sdata (sd),
        .dac_sck (sck_r), .dac_sdi (sdi_r), .dac_cs_n (cs_r)
    );

    logic [15:0] exp_l[$];
    logic [15:0] exp_r[$];
    string       tag_l[$];
    string       tag_r[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] to_offset(input logic [31:0] w);
        return {~w[31], w[30:16]};
    endfunction

    // ---------------- driver ----------------
    logic prev_r0 = 1'b0;

    task automatic drive_frame(input logic [31:0] lw, input logic [31:0] rw,
                               input bit push_r, input string tag);
        exp_l.push_back(to_offset(lw));
        tag_l.push_back(tag);
        if (push_r) begin
            exp_r.push_back(to_offset(rw));
            tag_r.push_back({tag, "/R7"});
        end
        for (int j = 0; j < 64; j++) begin
            @(negedge bclk);
            lr = (j < 32) ? 1'b0 : 1'b1;
            if (j == 0)       sd = prev_r0;
            else if (j <= 32) sd = lw[32 - j];
            else              sd = rw[64 - j];
            if (!rst_n) begin
                #2 rst_n = 1'b1;
            end
        end
        prev_r0 = rw[0];
    endtask

    // ---------------- monitors ----------------
    logic [15:0] sr_l, sr_r;
    int run_l = 0, tot_l = 0, run_r = 0, tot_r = 0;
    logic [15:0] e_l, e_r;
    string t_l, t_r;

    always @(posedge sck_l) if (rst_n) begin
        chk(bclk === 1'b1, "R8", {31'd0, bclk}, 32'd1);
        tot_l++;
        if (!cs_l) begin
            sr_l = {sr_l[14:0], sdi_l};
            run_l++;
        end
    end
    always @(negedge sck_l) if (rst_n) chk(bclk === 1'b0, "R8", {31'd0, bclk}, 32'd0);
    always @(sdi_l) if (rst_n) chk(bclk === 1'b0, "R8", {31'd0, bclk}, 32'd0);

    always @(posedge cs_l) if (rst_n) begin
        #1;
        chk(sck_l === 1'b1 && sdi_l === 1'b0, "R5", {30'd0, sck_l, sdi_l}, 32'd2);
        chk(run_l == 30, "R6", run_l, 30);
        chk(tot_l == 32, "R4", tot_l, 32);
        if (exp_l.size() == 0) begin
            chk(1'b0, "R2", {16'd0, sr_l}, 32'hffff_ffff);
        end else begin
            e_l = exp_l.pop_front();
            t_l = tag_l.pop_front();
            chk(sr_l === e_l, t_l, {16'd0, sr_l}, {16'd0, e_l});
        end
        run_l = 0;
        tot_l = 0;
    end

    always @(posedge sck_r) if (rst_n) begin
        chk(bclk === 1'b1, "R8", {31'd0, bclk}, 32'd1);
        tot_r++;
        if (!cs_r) begin
            sr_r = {sr_r[14:0], sdi_r};
            run_r++;
        end
    end
    always @(negedge sck_r) if (rst_n) chk(bclk === 1'b0, "R8", {31'd0, bclk}, 32'd0);
    always @(sdi_r) if (rst_n) chk(bclk === 1'b0, "R8", {31'd0, bclk}, 32'd0);

    always @(posedge cs_r) if (rst_n) begin
        #1;
        chk(sck_r === 1'b1 && sdi_r === 1'b0, "R5", {30'd0, sck_r, sdi_r}, 32'd2);
        chk(run_r == 30, "R6", run_r, 30);
        chk(tot_r == 32, "R4", tot_r, 32);
        if (exp_r.size() == 0) begin
            chk(1'b0, "R7", {16'd0, sr_r}, 32'hffff_ffff);
        end else begin
            e_r = exp_r.pop_front();
            t_r = tag_r.pop_front();
            chk(sr_r === e_r, t_r, {16'd0, sr_r}, {16'd0, e_r});
        end
        run_r = 0;
        tot_r = 0;
    end

    // ---------------- stimulus ----------------
    function automatic logic [31:0] lfsr_next(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge bclk);
        #1;
        // R1 reset state on both variants
        chk(cs_l === 1'b1 && sck_l === 1'b1 && sdi_l === 1'b0, "R1",
            {29'd0, cs_l, sck_l, sdi_l}, 32'd6);
        chk(cs_r === 1'b1 && sck_r === 1'b1 && sdi_r === 1'b0, "R1",
            {29'd0, cs_r, sck_r, sdi_r}, 32'd6);

        drive_frame(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R2");
        drive_frame(32'h0000_FFFF, 32'hFFFF_0000, 1'b1, "R3");   // low half ignored
        drive_frame(32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1, "R3");
        drive_frame(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R2");   // full-scale ends
        drive_frame(32'h0001_0000, 32'hFFFE_FFFF, 1'b1, "R2");
        seed = 32'hACE1_2468;
        for (int k = 0; k < 6; k++) begin
            logic [31:0] a, b;
            a    = lfsr_next(seed);
            b    = lfsr_next(a);
            seed = b;
            drive_frame(a, b, 1'b1, "R2");
        end
        // last frame: its right word would latch in a frame that is never sent
        drive_frame(32'h5A5A_C3C3, 32'h0, 1'b0, "R2");
        repeat (8) @(negedge bclk);

        chk(exp_l.size() == 0, "R5", exp_l.size(), 0);
        chk(exp_r.size() == 0, "R7", exp_r.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge bclk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule